// File: doc/BRIEF.md
# Quadlet Transmit FIFO with Control/Status Register

This block buffers 32-bit quadlets on their way from host software to a link transmitter. The host pushes a quadlet by writing it to a data port in a small register window. It observes and controls the queue through one 32-bit control/status word at offset 34h. The transmitter drains the queue through a valid/ready stream. A quadlet moves only on a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the head quadlet and `tx_valid` stay put.

The usable depth can be set at run time in quadlets, up to the physical storage depth. Every fill flag is computed against that active depth. The flags come from a register. They are computed from the occupancy and active depth that will hold after each edge, so a read of the status word in the cycle after an operation already shows its effect. A write with the flush bit set empties the queue at once.

Top module: `quad_tx_fifo`

## Requirements
- R1: While reset is asserted, a read of offset 34h returns 0000_0000h and `tx_valid` is 0.
- R2: One cycle after reset is released, the status word reads 0000_8010h. That is the empty flag (bit 15) plus the four-free flag (bit 4), with the size field at 0 standing for the physical depth of 16.
- R3: A write to offset 30h pushes `reg_wdata`. Quadlets leave on `tx_data` in the order they were pushed, and `tx_valid` is high exactly when at least one quadlet is stored.
- R4: Bit 0 (full) is set when the number stored is at least the active depth. A push made while full is dropped, and the stored contents are left unchanged.
- R5: Bit 1 is set when exactly one free location remains below the active depth.
- R6: Bit 4 is set when four or more locations are free.
- R7: Bit 14 is set when exactly one quadlet is stored. Bit 15 is set when none is stored.
- R8: A write to 34h with bit 19 set discards all entries in that cycle. Bit 19 always reads back as 0.
- R9: Bits 31:23 hold the active depth. A write to 34h stores bits 31:23 of the written data. A value of 0, or a value above the physical depth, is stored as the physical depth. Shrinking the depth below the current occupancy reports full.
- R10: Flag bits ignore host writes. Bits 2–3, 5–13, 16–18 and 20–22 read as 0, and any offset other than 34h reads as 0.
- R11: A push and a pop in the same cycle leave the occupancy unchanged. Flags reflect each operation one cycle after it is made.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value and `tx_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register (combinational) |
| tx_valid | output | 1 | A quadlet is available to the transmitter |
| tx_ready | input | 1 | The transmitter takes the head quadlet |
| tx_data | output | 32 | Head quadlet |

## Verification
The assertions check the following on every cycle:
- the occupancy never exceeds the physical depth;
- a registered full flag always blocks acceptance of a push;
- full and empty never appear together;
- a flush always leaves the queue empty;
- a paired push and pop keep the count steady;
- the stream's head holds under back-pressure;
- the stored depth stays within range.

Ordering of data across wrap-around, the exact flag word after each fill level, and clamping of out-of-range sizes can only be shown by the bench's scenarios. The same holds for flag writes being ignored, a shrink below the occupancy, and the reset-time read value.

// File: rtl/quad_fifo_pkg.sv
package quad_fifo_pkg;
  localparam int QW         = 32;
  localparam int REG_AW     = 8;
  localparam int SIZE_W     = 9;
  localparam int SIZE_LSB   = 23;
  localparam int BIT_FULL   = 0;
  localparam int BIT_AFULL  = 1;
  localparam int BIT_ROOM4  = 4;
  localparam int BIT_AEMPTY = 14;
  localparam int BIT_EMPTY  = 15;
  localparam int BIT_FLUSH  = 19;
  localparam logic [REG_AW-1:0] DATA_OFS = 8'h30;
  localparam logic [REG_AW-1:0] CTRL_OFS = 8'h34;

  typedef struct packed {
    logic full;
    logic afull;
    logic room4;
    logic aempty;
    logic empty;
  } fill_flags_t;
endpackage

// File: rtl/qf_regif.sv
module qf_regif
  import quad_fifo_pkg::*;
#(
  parameter int PHYS_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [QW-1:0]     reg_wdata,
  input  fill_flags_t       flags,
  output logic [QW-1:0]     reg_rdata,
  output logic              push_req,
  output logic [QW-1:0]     push_data,
  output logic              flush,
  output logic [SIZE_W-1:0] size_q,
  output logic [SIZE_W-1:0] size_nxt
);
  localparam logic [SIZE_W-1:0] PHYS_S = SIZE_W'(PHYS_DEPTH);

  logic              wr_ctrl;
  logic [SIZE_W-1:0] size_in;
  logic [SIZE_W-1:0] size_clamped;
  logic [QW-1:0]     stat_word;

  assign wr_ctrl   = reg_wr && (reg_addr == CTRL_OFS);
  assign push_req  = reg_wr && (reg_addr == DATA_OFS);
  assign push_data = reg_wdata;
  assign flush     = wr_ctrl && reg_wdata[BIT_FLUSH];

  assign size_in      = reg_wdata[SIZE_LSB +: SIZE_W];
  assign size_clamped = ((size_in == '0) || (size_in > PHYS_S)) ? PHYS_S : size_in;
  assign size_nxt     = wr_ctrl ? size_clamped : size_q;

  always_ff @(posedge clk) begin
    if (!rst_n) size_q <= '0;
    else        size_q <= size_nxt;
  end

  always_comb begin
    stat_word                       = '0;
    stat_word[BIT_FULL]             = flags.full;
    stat_word[BIT_AFULL]            = flags.afull;
    stat_word[BIT_ROOM4]            = flags.room4;
    stat_word[BIT_AEMPTY]           = flags.aempty;
    stat_word[BIT_EMPTY]            = flags.empty;
    stat_word[SIZE_LSB +: SIZE_W]   = size_q;
    reg_rdata = (reg_addr == CTRL_OFS) ? stat_word : '0;
  end

  assert_size_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    size_q <= PHYS_S);
  assert_size_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (size_q != '0) && (size_q <= PHYS_S));
endmodule

// File: rtl/qf_occupancy.sv
module qf_occupancy
  import quad_fifo_pkg::*;
#(
  parameter int PHYS_DEPTH = 16,
  localparam int CNT_W = $clog2(PHYS_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic              flush,
  input  logic [SIZE_W-1:0] size_q,
  input  logic [SIZE_W-1:0] size_nxt,
  output logic              push_ok,
  output logic              pop_ok,
  output logic              out_valid,
  output fill_flags_t       flags
);
  localparam logic [CNT_W-1:0] PHYS_C = CNT_W'(PHYS_DEPTH);
  localparam logic [CNT_W-1:0] FOUR_C = CNT_W'(4);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  function automatic logic [CNT_W-1:0] eff_of(input logic [SIZE_W-1:0] s);
    if (s == '0) return PHYS_C;
    return CNT_W'(s);
  endfunction

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] count_nxt;
  logic [CNT_W-1:0] cap_now;
  logic [CNT_W-1:0] cap_nxt;
  logic [CNT_W-1:0] free_nxt;

  assign cap_now   = eff_of(size_q);
  assign cap_nxt   = eff_of(size_nxt);
  assign push_ok   = push_req && !flush && (count < cap_now);
  assign pop_ok    = pop_req && !flush && (count != '0);
  assign out_valid = (count != '0);

  always_comb begin
    if (flush) count_nxt = '0;
    else       count_nxt = count + CNT_W'(push_ok) - CNT_W'(pop_ok);
    free_nxt = (cap_nxt > count_nxt) ? (cap_nxt - count_nxt) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      flags <= '0;
    end else begin
      count        <= count_nxt;
      flags.full   <= (count_nxt >= cap_nxt);
      flags.afull  <= (free_nxt == ONE_C);
      flags.room4  <= (free_nxt >= FOUR_C);
      flags.aempty <= (count_nxt == ONE_C);
      flags.empty  <= (count_nxt == '0);
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= PHYS_C);
  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flags.full |-> !push_ok);
  assert_full_empty_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flags.full, flags.empty}));
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
  assert_pushpop_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> (count == $past(count)));
endmodule

// File: rtl/qf_store.sv
module qf_store
  import quad_fifo_pkg::*;
#(
  parameter int PHYS_DEPTH = 16,
  localparam int PTR_W = (PHYS_DEPTH > 1) ? $clog2(PHYS_DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_ok,
  input  logic [QW-1:0] push_data,
  input  logic          pop_ok,
  input  logic          flush,
  output logic [QW-1:0] head_data
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(PHYS_DEPTH - 1);

  logic [QW-1:0]    mem [PHYS_DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
    end
  end

  assign head_data = mem[rd_ptr];

  assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr <= LAST) && (rd_ptr <= LAST));
endmodule

// File: rtl/quad_tx_fifo.sv
module quad_tx_fifo
  import quad_fifo_pkg::*;
#(
  parameter int PHYS_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [31:0] tx_data
);
  fill_flags_t       flags;
  logic              push_req;
  logic [QW-1:0]     push_data;
  logic              flush;
  logic [SIZE_W-1:0] size_q;
  logic [SIZE_W-1:0] size_nxt;
  logic              push_ok;
  logic              pop_ok;

  qf_regif #(.PHYS_DEPTH(PHYS_DEPTH)) regif_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .flags(flags), .reg_rdata(reg_rdata),
    .push_req(push_req), .push_data(push_data), .flush(flush),
    .size_q(size_q), .size_nxt(size_nxt)
  );

  qf_occupancy #(.PHYS_DEPTH(PHYS_DEPTH)) occ_i (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(tx_ready),
    .flush(flush), .size_q(size_q), .size_nxt(size_nxt),
    .push_ok(push_ok), .pop_ok(pop_ok), .out_valid(tx_valid), .flags(flags)
  );

  qf_store #(.PHYS_DEPTH(PHYS_DEPTH)) store_i (
    .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .push_data(push_data),
    .pop_ok(pop_ok), .flush(flush), .head_data(tx_data)
  );

  assert_hold_under_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !flush) |=> (tx_valid && $stable(tx_data)));
  assert_empty_no_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flags.empty |-> !tx_valid);
endmodule

// File: tb/quad_tx_fifo_tb_top.sv
module quad_tx_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = 8'h34;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [31:0] tx_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  quad_tx_fifo #(.PHYS_DEPTH(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic        rdy;
    logic [31:0] exp_st;
    logic        exp_v;
    logic [31:0] exp_d;
  } vec_t;

  // Status bits: 0 full, 1 one-free, 4 four-free, 14 one-stored, 15 empty, 31:23 size.
  localparam vec_t VECS [0:9] = '{
    '{1'b1, 8'h34, 32'h0300_0000, 1'b0, 32'h0300_8010, 1'b0, 32'h0},          // R9 size 6
    '{1'b1, 8'h30, 32'hA000_0001, 1'b0, 32'h0300_4010, 1'b1, 32'hA000_0001}, // R7 R6
    '{1'b1, 8'h30, 32'hA000_0002, 1'b0, 32'h0300_0010, 1'b1, 32'hA000_0001}, // R6
    '{1'b1, 8'h30, 32'hA000_0003, 1'b0, 32'h0300_0000, 1'b1, 32'hA000_0001},
    '{1'b1, 8'h30, 32'hA000_0004, 1'b0, 32'h0300_0000, 1'b1, 32'hA000_0001},
    '{1'b1, 8'h30, 32'hA000_0005, 1'b0, 32'h0300_0002, 1'b1, 32'hA000_0001}, // R5
    '{1'b1, 8'h30, 32'hA000_0006, 1'b0, 32'h0300_0001, 1'b1, 32'hA000_0001}, // R4
    '{1'b1, 8'h30, 32'hA000_0007, 1'b0, 32'h0300_0001, 1'b1, 32'hA000_0001}, // R4 drop
    '{1'b0, 8'h34, 32'h0,         1'b1, 32'h0300_0002, 1'b1, 32'hA000_0002}, // R3 pop
    '{1'b1, 8'h30, 32'hA000_0008, 1'b1, 32'h0300_0002, 1'b1, 32'hA000_0003}  // R11
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Apply one operation for one edge, then idle with a status read selected.
  task automatic step(input logic wr, input logic [7:0] addr, input logic [31:0] wd,
                      input logic rdy);
    @(negedge clk);
    reg_wr = wr; reg_addr = addr; reg_wdata = wd; tx_ready = rdy;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h34; reg_wdata = '0; tx_ready = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 status in reset", reg_rdata, 32'h0);
    chk("R1 valid in reset", {31'b0, tx_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R2 status after reset", reg_rdata, 32'h0000_8010);

    for (int i = 0; i < 10; i++) begin
      step(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].rdy);
      chk($sformatf("R4-R11 vector %0d status", i), reg_rdata, VECS[i].exp_st);
      chk($sformatf("R3 vector %0d valid", i), {31'b0, tx_valid}, {31'b0, VECS[i].exp_v});
      if (VECS[i].exp_v) chk($sformatf("R3 vector %0d data", i), tx_data, VECS[i].exp_d);
    end

    // R3: drain in order, A7 was dropped
    begin
      logic [31:0] order [5] = '{32'hA000_0003, 32'hA000_0004, 32'hA000_0005,
                                 32'hA000_0006, 32'hA000_0008};
      for (int k = 0; k < 5; k++) begin
        chk("R3 drain order", tx_data, order[k]);
        step(1'b0, 8'h34, 32'h0, 1'b1);
      end
    end
    chk("R3 empty after drain", reg_rdata, 32'h0300_8010);
    chk("R3 valid low after drain", {31'b0, tx_valid}, 32'h0);

    // R12: back-pressure holds the head
    step(1'b1, 8'h30, 32'hB000_0001, 1'b0);
    step(1'b1, 8'h30, 32'hB000_0002, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk("R12 data held", tx_data, 32'hB000_0001);
      chk("R12 valid held", {31'b0, tx_valid}, 32'h1);
    end

    // R8: flush
    step(1'b1, 8'h34, 32'h0308_0000, 1'b0);
    chk("R8 flushed status, clear bit reads 0", reg_rdata, 32'h0300_8010);
    chk("R8 valid after flush", {31'b0, tx_valid}, 32'h0);

    // R10: flag and reserved bits ignore writes
    step(1'b1, 8'h34, 32'h0377_FFFF, 1'b0);
    chk("R10 read-only bits", reg_rdata, 32'h0300_8010);
    reg_addr = 8'h38; #1;
    chk("R10 other offset reads 0", reg_rdata, 32'h0);
    reg_addr = 8'h34; #1;

    // R9: clamping and shrink
    step(1'b1, 8'h34, 32'h0000_0000, 1'b0);
    chk("R9 size 0 clamps", reg_rdata, 32'h0800_8010);
    step(1'b1, 8'h34, 32'h3200_0000, 1'b0);
    chk("R9 size 100 clamps", reg_rdata, 32'h0800_8010);
    step(1'b1, 8'h34, 32'h0180_0000, 1'b0);
    chk("R9 size 3 no four-free", reg_rdata, 32'h0180_8000);
    step(1'b1, 8'h30, 32'hC000_0001, 1'b0);
    chk("R7 one stored", reg_rdata, 32'h0180_4000);
    step(1'b1, 8'h30, 32'hC000_0002, 1'b0);
    chk("R5 one free", reg_rdata, 32'h0180_0002);
    step(1'b1, 8'h30, 32'hC000_0003, 1'b0);
    chk("R4 full at size 3", reg_rdata, 32'h0180_0001);
    step(1'b1, 8'h34, 32'h0100_0000, 1'b0);
    chk("R9 shrink below count reports full", reg_rdata, 32'h0100_0001);
    step(1'b1, 8'h30, 32'hC000_0004, 1'b0);
    chk("R4 head unchanged after dropped push", tx_data, 32'hC000_0001);
    step(1'b0, 8'h34, 32'h0, 1'b1);
    chk("R9 still full after one pop", reg_rdata, 32'h0100_0001);
    chk("R3 next head", tx_data, 32'hC000_0002);
    step(1'b0, 8'h34, 32'h0, 1'b1);
    chk("R5 one free after second pop", reg_rdata, 32'h0100_4002);
    chk("R3 last head", tx_data, 32'hC000_0003);

    finish_run();
  end
endmodule